// File: doc/BRIEF.md
# Register Profile Store/Restore Sequencer

This block moves a configuration profile between a live register space and a byte-wide non-volatile memory. A small command buffer holds a stream of register-section groups and single-byte opcodes. A group header is three bytes: a count byte, then the high and low bytes of a 16-bit base address. The count byte has bit 7 clear. Its bits [6:0] give the number of registers minus one, so 0x00 means one register and 0x7F means 128. A byte with bit 7 set is an opcode: 0x80 requests a shadow-to-active bank transfer, 0xFE is a pause, and 0xFF ends the stream.

In store mode the sequencer walks the command buffer. For each group it writes the three header bytes to non-volatile memory, followed by the current value of every register in the group. It also copies each opcode it meets. A pause halts the pass, and a later store pass continues at the memory address where the paused pass stopped. This lets a stream that is longer than the buffer be built up in several refills. In restore mode the sequencer reads the memory from address zero. It writes each stored value into the shadow register bank and pulses a transfer strobe at every 0x80.

Throughout a run the block holds busy high and takes the host serial-port enable away.

Top module: `regprof_sequencer`

## Requirements
- R1: In store mode, a group with count byte c (bit 7 clear) and base address {hi,lo} places c, hi, lo in the memory. These are followed by c+1 register values read from base, base+1, ... in that order, so 0x00 stores one value and 0x7F stores 128.
- R2: In store mode, opcode 0x80 is copied to the memory. In restore mode, each 0x80 produces a `bank_xfer` pulse exactly one cycle wide, in stream order with the shadow writes.
- R3: Opcode 0xFF is written and ends a store, and it ends a restore. Afterwards `busy` is 0, `sport_en` is 1, `store_active` is 0 and `err` is 0.
- R4: In store mode, opcode 0xFE is written and then the pass halts: `store_active` clears and `sport_en` returns to 1. The next `store_go` continues writing at the memory address that follows the 0xFE.
- R5: A store that starts after reset, after 0xFF or after an error begins at memory address 0.
- R6: A restore reads from memory address 0. For every stored group it issues one `reg_we` per register, at addresses base+i with the stored values, and performs no other register write.
- R7: During a restore, 0xFE is skipped and reading continues with the next byte.
- R8: A restore that reaches the last memory address without finding 0xFF ends normally, with `err` 0.
- R9: A stream byte with bit 7 set other than 0x80, 0xFE or 0xFF ends the run with `err` 1, and no memory or register write follows that byte. `err` clears on the next start.
- R10: A store that runs past the last command-buffer byte, or that needs a memory byte past the last address, ends with `err` 1.
- R11: After reset, `busy`, `err` and `store_active` are 0 and `sport_en` is 1. A start raises `busy` and lowers `sport_en` on the next cycle. Starts received while `busy` is high are ignored.
- R12: `nv_req` stays asserted with stable `nv_addr`, `nv_we` and `nv_wdata` until a cycle in which `nv_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_go | input | 1 | One-cycle store request (store bit plus update strobe) |
| restore_go | input | 1 | One-cycle restore request |
| busy | output | 1 | Sequencer running |
| sport_en | output | 1 | Host serial-port enable, low while running |
| store_active | output | 1 | Store-request bit, cleared at pause, end or error |
| err | output | 1 | Last run ended on a bad code or an overflow |
| cmd_addr | output | CMD_AW | Command buffer read address |
| cmd_data | input | 8 | Command buffer byte, combinational read |
| reg_addr | output | RA_W | Register space address |
| reg_rdata | input | 8 | Live register value, combinational read |
| reg_we | output | 1 | Shadow register write strobe |
| reg_wdata | output | 8 | Shadow register write value |
| bank_xfer | output | 1 | Shadow-to-active transfer pulse |
| nv_req | output | 1 | Memory access request |
| nv_we | output | 1 | Memory access is a write |
| nv_addr | output | NV_AW | Memory byte address |
| nv_wdata | output | 8 | Memory write byte |
| nv_rdata | input | 8 | Memory read byte, valid with nv_ready |
| nv_ready | input | 1 | Memory access completes this cycle |

## Verification
The hardest situation to reach is a store that pauses on 0xFE and then resumes at the retained memory address after the command buffer has been refilled. The bench chains two store passes with different buffer contents, then restores the combined stream and checks that both halves come back in order with the pause byte skipped. The two overflow endings and the end-of-memory restore are also awkward to reach. The bench reaches them by storing two 128-register groups into a 256-byte memory and by filling the memory model directly with 64 groups and no end code.

// File: rtl/rps_pkg.sv
package rps_pkg;

   localparam logic [7:0] OP_XFER  = 8'h80;
   localparam logic [7:0] OP_PAUSE = 8'hFE;
   localparam logic [7:0] OP_END   = 8'hFF;

   typedef enum logic [2:0] {
      K_GROUP,
      K_XFER,
      K_PAUSE,
      K_END,
      K_BAD
   } rps_kind_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_NVOP,
      S_FETCH,
      S_HI,
      S_LO,
      S_VAL,
      S_HALT,
      S_STOP,
      R_DEC,
      R_HI,
      R_LO,
      R_VAL
   } rps_state_e;

endpackage

// File: rtl/rps_classify.sv
module rps_classify
   import rps_pkg::*;
(
   input  logic [7:0] code,
   output rps_kind_e  kind
);

   always_comb begin
      if (!code[7]) begin
         kind = K_GROUP;
      end else begin
         case (code)
            OP_XFER:  kind = K_XFER;
            OP_PAUSE: kind = K_PAUSE;
            OP_END:   kind = K_END;
            default:  kind = K_BAD;
         endcase
      end
   end

endmodule

// File: rtl/rps_nvptr.sv
module rps_nvptr #(
   parameter int NV_DEPTH = 256,
   parameter int NV_AW    = $clog2(NV_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [NV_AW-1:0] addr,
   output logic             full
);

   localparam logic [NV_AW:0] LIMIT = NV_DEPTH[NV_AW:0];

   logic [NV_AW:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clear) begin
         ptr <= '0;
      end else if (step && !full) begin
         ptr <= ptr + 1'b1;
      end
   end

   assign addr = ptr[NV_AW-1:0];

   generate
      if ((1 << NV_AW) == NV_DEPTH) begin : g_pow2
         assign full = ptr[NV_AW];
      end else begin : g_cmp
         assign full = (ptr == LIMIT);
      end
   endgenerate

endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
   import rps_pkg::*;
#(
   parameter int CMD_DEPTH = 23,
   parameter int CMD_AW    = $clog2(CMD_DEPTH + 1),
   parameter int RA_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_go,
   input  logic              restore_go,
   output logic              busy,
   output logic              store_active,
   output logic              err,
   output logic [CMD_AW-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   output logic [RA_W-1:0]   reg_addr,
   input  logic [7:0]        reg_rdata,
   output logic              reg_we,
   output logic [7:0]        reg_wdata,
   output logic              bank_xfer,
   output logic              nv_req,
   output logic              nv_we,
   output logic [7:0]        nv_wdata,
   input  logic [7:0]        nv_rdata,
   input  logic              nv_ready,
   input  logic              nv_full,
   output logic              nv_clear,
   output logic              nv_step,
   output logic [7:0]        cls_byte,
   input  rps_kind_e         kind
);

   rps_state_e        state, ret;
   logic              mode_st, resume, nvwe;
   logic [CMD_AW-1:0] cmd_ptr;
   logic [6:0]        cnt, idx;
   logic [7:0]        hi, lo, wbyte, rbyte;
   logic [15:0]       base;
   logic              cmd_end, last;

   assign cmd_end   = (cmd_ptr == CMD_AW'(CMD_DEPTH));
   assign last      = (idx == cnt);
   assign base      = {hi, lo};
   assign cmd_addr  = cmd_ptr;
   assign cls_byte  = mode_st ? cmd_data : rbyte;
   assign reg_addr  = RA_W'(base + {9'd0, idx});
   assign reg_we    = (state == R_VAL);
   assign reg_wdata = rbyte;
   assign bank_xfer = (state == R_DEC) && (kind == K_XFER);
   assign nv_req    = (state == ST_NVOP) && !nv_full;
   assign nv_we     = nvwe;
   assign nv_wdata  = wbyte;
   assign nv_step   = nv_req && nv_ready;
   assign nv_clear  = (state == ST_IDLE) &&
                      ((store_go && !resume) || (!store_go && restore_go));
   assign busy      = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         ret          <= ST_IDLE;
         mode_st      <= 1'b0;
         resume       <= 1'b0;
         nvwe         <= 1'b0;
         cmd_ptr      <= '0;
         cnt          <= '0;
         idx          <= '0;
         hi           <= '0;
         lo           <= '0;
         wbyte        <= '0;
         rbyte        <= '0;
         store_active <= 1'b0;
         err          <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (store_go) begin
                  mode_st      <= 1'b1;
                  store_active <= 1'b1;
                  err          <= 1'b0;
                  cmd_ptr      <= '0;
                  nvwe         <= 1'b1;
                  state        <= S_FETCH;
               end else if (restore_go) begin
                  mode_st <= 1'b0;
                  err     <= 1'b0;
                  resume  <= 1'b0;
                  nvwe    <= 1'b0;
                  ret     <= R_DEC;
                  state   <= ST_NVOP;
               end
            end
            ST_NVOP: begin
               if (nv_full) begin
                  state        <= ST_IDLE;
                  store_active <= 1'b0;
                  resume       <= 1'b0;
                  err          <= mode_st;
               end else if (nv_ready) begin
                  if (!nvwe) rbyte <= nv_rdata;
                  state <= ret;
               end
            end
            S_FETCH, S_HI, S_LO: begin
               if (cmd_end || (state == S_FETCH && kind == K_BAD)) begin
                  state        <= ST_IDLE;
                  store_active <= 1'b0;
                  resume       <= 1'b0;
                  err          <= 1'b1;
               end else begin
                  wbyte   <= cmd_data;
                  cmd_ptr <= cmd_ptr + 1'b1;
                  state   <= ST_NVOP;
                  if (state == S_HI) begin
                     hi  <= cmd_data;
                     ret <= S_LO;
                  end else if (state == S_LO) begin
                     lo  <= cmd_data;
                     idx <= '0;
                     ret <= S_VAL;
                  end else begin
                     case (kind)
                        K_GROUP: begin
                           cnt <= cmd_data[6:0];
                           ret <= S_HI;
                        end
                        K_XFER:  ret <= S_FETCH;
                        K_PAUSE: ret <= S_HALT;
                        default: ret <= S_STOP;
                     endcase
                  end
               end
            end
            S_VAL: begin
               wbyte <= reg_rdata;
               idx   <= idx + 1'b1;
               ret   <= last ? S_FETCH : S_VAL;
               state <= ST_NVOP;
            end
            S_HALT: begin
               state        <= ST_IDLE;
               store_active <= 1'b0;
               resume       <= 1'b1;
            end
            S_STOP: begin
               state        <= ST_IDLE;
               store_active <= 1'b0;
               resume       <= 1'b0;
            end
            R_DEC: begin
               case (kind)
                  K_GROUP: begin
                     cnt   <= rbyte[6:0];
                     ret   <= R_HI;
                     state <= ST_NVOP;
                  end
                  K_XFER, K_PAUSE: begin
                     ret   <= R_DEC;
                     state <= ST_NVOP;
                  end
                  K_END: state <= ST_IDLE;
                  default: begin
                     state <= ST_IDLE;
                     err   <= 1'b1;
                  end
               endcase
            end
            R_HI: begin
               hi    <= rbyte;
               ret   <= R_LO;
               state <= ST_NVOP;
            end
            R_LO: begin
               lo    <= rbyte;
               idx   <= '0;
               ret   <= R_VAL;
               state <= ST_NVOP;
            end
            R_VAL: begin
               if (!last) idx <= idx + 1'b1;
               ret   <= last ? R_DEC : R_VAL;
               state <= ST_NVOP;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/regprof_sequencer.sv
module regprof_sequencer
   import rps_pkg::*;
#(
   parameter int CMD_DEPTH = 23,
   parameter int NV_DEPTH  = 256,
   parameter int RA_W      = 16,
   localparam int CMD_AW   = $clog2(CMD_DEPTH + 1),
   localparam int NV_AW    = $clog2(NV_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_go,
   input  logic              restore_go,
   output logic              busy,
   output logic              sport_en,
   output logic              store_active,
   output logic              err,
   output logic [CMD_AW-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   output logic [RA_W-1:0]   reg_addr,
   input  logic [7:0]        reg_rdata,
   output logic              reg_we,
   output logic [7:0]        reg_wdata,
   output logic              bank_xfer,
   output logic              nv_req,
   output logic              nv_we,
   output logic [NV_AW-1:0]  nv_addr,
   output logic [7:0]        nv_wdata,
   input  logic [7:0]        nv_rdata,
   input  logic              nv_ready
);

   generate
      if (CMD_DEPTH < 3 || CMD_DEPTH > 255) begin : g_cmd_range
         $error("CMD_DEPTH must lie in 3..255");
      end
      if (NV_DEPTH < 4) begin : g_nv_range
         $error("NV_DEPTH must be at least 4");
      end
      if (RA_W < 8 || RA_W > 16) begin : g_ra_range
         $error("RA_W must lie in 8..16");
      end
   endgenerate

   logic      nv_full, nv_clear, nv_step;
   logic [7:0] cls_byte;
   rps_kind_e kind;

   rps_classify u_cls (
      .code (cls_byte),
      .kind (kind)
   );

   rps_nvptr #(.NV_DEPTH(NV_DEPTH), .NV_AW(NV_AW)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (nv_clear),
      .step  (nv_step),
      .addr  (nv_addr),
      .full  (nv_full)
   );

   rps_fsm #(.CMD_DEPTH(CMD_DEPTH), .CMD_AW(CMD_AW), .RA_W(RA_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .store_go     (store_go),
      .restore_go   (restore_go),
      .busy         (busy),
      .store_active (store_active),
      .err          (err),
      .cmd_addr     (cmd_addr),
      .cmd_data     (cmd_data),
      .reg_addr     (reg_addr),
      .reg_rdata    (reg_rdata),
      .reg_we       (reg_we),
      .reg_wdata    (reg_wdata),
      .bank_xfer    (bank_xfer),
      .nv_req       (nv_req),
      .nv_we        (nv_we),
      .nv_wdata     (nv_wdata),
      .nv_rdata     (nv_rdata),
      .nv_ready     (nv_ready),
      .nv_full      (nv_full),
      .nv_clear     (nv_clear),
      .nv_step      (nv_step),
      .cls_byte     (cls_byte),
      .kind         (kind)
   );

   assign sport_en = !busy;

endmodule

// File: rtl/regprof_sequencer_chk.sv
module regprof_sequencer_chk #(
   parameter int NV_AW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             store_go,
   input logic             busy,
   input logic             store_active,
   input logic             err,
   input logic             bank_xfer,
   input logic             reg_we,
   input logic             nv_req,
   input logic             nv_we,
   input logic             nv_ready,
   input logic [NV_AW-1:0] nv_addr,
   input logic [7:0]       nv_wdata
);

   // R11
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_go && !busy |=> busy && store_active);

   // R12
   nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nv_req && !nv_ready |=> nv_req && $stable(nv_addr) && $stable(nv_wdata) && $stable(nv_we));

   // R2
   xfer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_xfer |=> !bank_xfer);

   // R6
   shadow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> busy && !store_active);

   // R5
   nv_write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nv_req && nv_we |-> store_active);

   // R9
   err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !busy && $past(busy));

endmodule

bind regprof_sequencer regprof_sequencer_chk #(.NV_AW(NV_AW)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .store_go     (store_go),
   .busy         (busy),
   .store_active (store_active),
   .err          (err),
   .bank_xfer    (bank_xfer),
   .reg_we       (reg_we),
   .nv_req       (nv_req),
   .nv_we        (nv_we),
   .nv_ready     (nv_ready),
   .nv_addr      (nv_addr),
   .nv_wdata     (nv_wdata)
);

// File: tb/regprof_sequencer_tb_top.sv
module regprof_sequencer_tb_top;

   localparam int CMD_DEPTH = 23;
   localparam int NV_DEPTH  = 256;
   localparam int CMD_AW    = $clog2(CMD_DEPTH + 1);
   localparam int NV_AW     = $clog2(NV_DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              store_go = 1'b0, restore_go = 1'b0;
   logic              busy, sport_en, store_active, err;
   logic [CMD_AW-1:0] cmd_addr;
   logic [7:0]        cmd_data;
   logic [15:0]       reg_addr;
   logic [7:0]        reg_rdata, reg_wdata;
   logic              reg_we, bank_xfer;
   logic              nv_req, nv_we, nv_ready;
   logic [NV_AW-1:0]  nv_addr;
   logic [7:0]        nv_wdata, nv_rdata;

   logic [7:0] cmd_mem [0:CMD_DEPTH-1];
   logic [7:0] live    [0:1023];
   logic [7:0] nvm     [0:NV_DEPTH-1];

   int vectors = 0, miscmp = 0;
   int lat = 0, wcnt = 0;
   logic             tb_wr = 1'b0;
   logic [NV_AW-1:0] tb_waddr = '0;
   logic [7:0]       tb_wdata = '0;
   logic [24:0]      exp_q [$];
   string            sb_tag = "R6";
   int               hs_seen = 0, hs_bad = 0;
   logic             done = 1'b0;

   regprof_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .store_go(store_go), .restore_go(restore_go),
      .busy(busy), .sport_en(sport_en), .store_active(store_active), .err(err),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .bank_xfer(bank_xfer),
      .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr), .nv_wdata(nv_wdata),
      .nv_rdata(nv_rdata), .nv_ready(nv_ready)
   );

   assign cmd_data  = (int'(cmd_addr) < CMD_DEPTH) ? cmd_mem[cmd_addr] : 8'h00;
   assign reg_rdata = live[reg_addr[9:0]];
   assign nv_rdata  = nvm[nv_addr];
   assign nv_ready  = nv_req && (wcnt >= lat);

   // memory model
   always @(posedge clk) begin
      if (tb_wr) nvm[tb_waddr] <= tb_wdata;
      else if (nv_req && nv_ready && nv_we) nvm[nv_addr] <= nv_wdata;
      if (nv_req && !nv_ready) wcnt <= wcnt + 1;
      else wcnt <= 0;
   end

   function automatic logic [7:0] lv(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscmp++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      logic [24:0] act;
      logic [24:0] e;
      if (rst_n && (reg_we || bank_xfer)) begin
         act = bank_xfer ? {1'b1, 24'h0} : {1'b0, reg_addr, reg_wdata};
         if (exp_q.size() == 0) begin
            check({sb_tag, " unexpected event"}, {7'd0, act}, 32'hFFFF_FFFF);
         end else begin
            e = exp_q.pop_front();
            check({sb_tag, " event"}, {7'd0, act}, {7'd0, e});
         end
      end
   end

   // R12 handshake observer
   logic             p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0;
   logic [NV_AW-1:0] p_addr = '0;
   logic [7:0]       p_wd = '0;
   always @(negedge clk) begin
      if (rst_n && p_req && !p_rdy) begin
         hs_seen++;
         if (!(nv_req && nv_addr == p_addr && nv_we == p_we && nv_wdata == p_wd)) hs_bad++;
      end
      p_req = nv_req; p_rdy = nv_ready; p_we = nv_we; p_addr = nv_addr; p_wd = nv_wdata;
   end

   task automatic push_w(input int a, input logic [7:0] d);
      exp_q.push_back({1'b0, 16'(a), d});
   endtask

   task automatic push_x();
      exp_q.push_back({1'b1, 24'h0});
   endtask

   task automatic poke(input int a, input logic [7:0] d);
      @(negedge clk);
      tb_wr = 1'b1; tb_waddr = NV_AW'(a); tb_wdata = d;
      @(negedge clk);
      tb_wr = 1'b0;
   endtask

   task automatic fill_nv(input logic [7:0] d);
      for (int a = 0; a < NV_DEPTH; a++) begin
         @(negedge clk);
         tb_wr = 1'b1; tb_waddr = NV_AW'(a); tb_wdata = d;
      end
      @(negedge clk);
      tb_wr = 1'b0;
   endtask

   task automatic pulse(input bit st);
      @(negedge clk);
      if (st) store_go = 1'b1; else restore_go = 1'b1;
      @(negedge clk);
      store_go = 1'b0; restore_go = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
   endtask

   task automatic clr_cmd();
      for (int i = 0; i < CMD_DEPTH; i++) cmd_mem[i] = 8'hFF;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscmp++; vectors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 1024; i++) live[i] = lv(i);
      for (int i = 0; i < NV_DEPTH; i++) nvm[i] = 8'hFF;
      clr_cmd();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 reset busy", busy, 0);
      check("R11 reset sport_en", sport_en, 1);
      check("R11 reset err", err, 0);
      check("R11 reset store_active", store_active, 0);

      // T1: plain store (R1 R2 R3 R11)
      lat = 2;
      cmd_mem[0] = 8'h02; cmd_mem[1] = 8'h00; cmd_mem[2] = 8'h10;
      cmd_mem[3] = 8'h00; cmd_mem[4] = 8'h01; cmd_mem[5] = 8'h00;
      cmd_mem[6] = 8'h80; cmd_mem[7] = 8'hFF;
      pulse(1);
      check("R11 busy after start", busy, 1);
      check("R11 sport_en after start", sport_en, 0);
      wait_idle();
      check("R3 busy end", busy, 0);
      check("R3 sport_en end", sport_en, 1);
      check("R3 store_active end", store_active, 0);
      check("R3 err end", err, 0);
      check("R1 nv0", nvm[0], 8'h02);
      check("R1 nv1", nvm[1], 8'h00);
      check("R1 nv2", nvm[2], 8'h10);
      check("R1 nv3", nvm[3], lv(16));
      check("R1 nv4", nvm[4], lv(17));
      check("R1 nv5", nvm[5], lv(18));
      check("R1 nv6", nvm[6], 8'h00);
      check("R1 nv8", nvm[8], 8'h00);
      check("R1 nv9", nvm[9], lv(256));
      check("R2 nv10", nvm[10], 8'h80);
      check("R3 nv11", nvm[11], 8'hFF);

      // T2: restore (R6 R2 R3)
      lat = 0; sb_tag = "R6";
      push_w(16, lv(16)); push_w(17, lv(17)); push_w(18, lv(18));
      push_w(256, lv(256)); push_x();
      pulse(0);
      check("R11 busy restore", busy, 1);
      wait_idle();
      check("R6 all events seen", exp_q.size(), 0);
      check("R3 restore err", err, 0);

      // T3: pause and resume (R4 R7)
      fill_nv(8'hFF);
      lat = 1; clr_cmd();
      cmd_mem[0] = 8'h00; cmd_mem[1] = 8'h00; cmd_mem[2] = 8'h20; cmd_mem[3] = 8'hFE;
      pulse(1);
      wait_idle();
      check("R4 store_active cleared", store_active, 0);
      check("R4 sport_en back", sport_en, 1);
      check("R4 err", err, 0);
      check("R4 value", nvm[3], lv(32));
      check("R4 pause byte", nvm[4], 8'hFE);
      clr_cmd();
      cmd_mem[0] = 8'h01; cmd_mem[1] = 8'h00; cmd_mem[2] = 8'h30;
      cmd_mem[3] = 8'h80; cmd_mem[4] = 8'hFF;
      pulse(1);
      wait_idle();
      check("R4 resume nv5", nvm[5], 8'h01);
      check("R4 resume nv7", nvm[7], 8'h30);
      check("R4 resume nv8", nvm[8], lv(48));
      check("R4 resume nv9", nvm[9], lv(49));
      check("R4 resume nv10", nvm[10], 8'h80);
      check("R4 resume nv11", nvm[11], 8'hFF);
      sb_tag = "R7";
      push_w(32, lv(32)); push_w(48, lv(48)); push_w(49, lv(49)); push_x();
      pulse(0);
      wait_idle();
      check("R7 pause skipped", exp_q.size(), 0);
      check("R7 err", err, 0);

      // T4: store after end restarts at zero (R5)
      clr_cmd();
      cmd_mem[0] = 8'h80; cmd_mem[1] = 8'hFF;
      pulse(1);
      wait_idle();
      check("R5 nv0", nvm[0], 8'h80);
      check("R5 nv1", nvm[1], 8'hFF);
      check("R5 nv2 untouched", nvm[2], 8'h20);

      // T5: bad code (R9)
      fill_nv(8'h5A);
      clr_cmd();
      cmd_mem[0] = 8'h00; cmd_mem[1] = 8'h00; cmd_mem[2] = 8'h40; cmd_mem[3] = 8'h90;
      pulse(1);
      wait_idle();
      check("R9 store err", err, 1);
      check("R9 store busy", busy, 0);
      check("R9 store_active", store_active, 0);
      check("R9 value stored", nvm[3], lv(64));
      check("R9 no write after bad", nvm[4], 8'h5A);
      poke(4, 8'h85);
      sb_tag = "R9";
      push_w(64, lv(64));
      pulse(0);
      wait_idle();
      check("R9 restore err", err, 1);
      check("R9 restore events", exp_q.size(), 0);

      // T6: command buffer overflow (R10)
      for (int k = 0; k < 7; k++) begin
         cmd_mem[3*k] = 8'h00; cmd_mem[3*k+1] = 8'h00; cmd_mem[3*k+2] = 8'(8'h50 + k);
      end
      cmd_mem[21] = 8'h80; cmd_mem[22] = 8'h80;
      pulse(1);
      check("R9 err cleared on start", err, 0);
      wait_idle();
      check("R10 cmd overflow err", err, 1);
      check("R10 last group value", nvm[27], lv(8'h56));
      check("R10 opcode 28", nvm[28], 8'h80);
      check("R10 opcode 29", nvm[29], 8'h80);

      // T7: memory overflow with 128-register groups (R10 R1)
      lat = 0; clr_cmd();
      cmd_mem[0] = 8'h7F; cmd_mem[1] = 8'h00; cmd_mem[2] = 8'h00;
      cmd_mem[3] = 8'h7F; cmd_mem[4] = 8'h01; cmd_mem[5] = 8'h00;
      cmd_mem[6] = 8'hFF;
      pulse(1);
      wait_idle();
      check("R10 nv overflow err", err, 1);
      check("R1 first of 128", nvm[3], lv(0));
      check("R1 last of 128", nvm[130], lv(127));
      check("R1 second header", nvm[131], 8'h7F);
      check("R10 last byte", nvm[255], lv(256 + 121));

      // T8: restore to end of memory (R8 R11)
      lat = 1;
      for (int k = 0; k < 64; k++) begin
         poke(4*k, 8'h00); poke(4*k+1, 8'h00);
         poke(4*k+2, 8'(k)); poke(4*k+3, 8'(k ^ 8'hC3));
      end
      sb_tag = "R8";
      for (int k = 0; k < 64; k++) push_w(k, 8'(k ^ 8'hC3));
      pulse(0);
      repeat (30) @(negedge clk);
      pulse(1);
      check("R11 start ignored while busy", store_active, 0);
      wait_idle();
      check("R8 all writes", exp_q.size(), 0);
      check("R8 no err", err, 0);
      check("R8 idle", busy, 0);

      // R12 handshake summary
      check("R12 hold violations", hs_bad, 0);
      check("R12 waits observed", (hs_seen > 0) ? 1 : 0, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end

endmodule